// File: doc/BRIEF.md
# Load/Store Dispatch Ordering Unit

This block sits at the dispatch stage of a load/store pipeline. It counts how many entries of a load queue and a store queue are in use, and reports whether the memory operation on its inputs can be taken. Each capacity is a parameter, and a capacity of zero means that queue is unbounded. When an operation is accepted, the block gives it a dependency group and emits, on the same cycle, the older groups it has to wait for. These dependencies enforce a weak memory ordering policy.

Each request carries three flags: may-load, may-store and side-effect. The side-effect flag turns an operation into a barrier. With may-load it is a load barrier, with may-store a store barrier, and with both a full barrier. A configuration bit declares that loads never alias older stores. When that bit is set, loads are released from waiting on stores. Two free events return entries: load retirement and store commit. The block tracks four registers: the youngest load group, the youngest load-barrier group, the youngest store group and the youngest store-barrier group. A group value of zero means "none".

All request outputs are combinational from the request inputs and the registered state. State changes take effect at the next rising clock edge.

Top module: `lsdo_dispatch_unit`

## Requirements
- R1: `avail_status` encoding: 0 means available, 1 means the load queue is full, 2 means the store queue is full. A may-load operation meeting a full load queue reports 1, even when the store queue is also full. A may-store operation meeting a full store queue reports 2 otherwise. An operation with neither flag always reports 0.
- R2: A queue counts as full only when its capacity is nonzero and its used count equals that capacity. With capacity 0, the status never reports that queue full.
- R3: An accepted operation takes one entry in the load queue if it may load, and one in the store queue if it may store. A `load_retire` pulse frees one load entry and a `store_commit` pulse frees one store entry. A free at count zero is ignored. A take and a free in the same cycle leave the count unchanged.
- R4: `disp_ack` is high exactly when `disp_valid` is high, reset is released and the status is 0. A rejected request changes no counter and no group state.
- R5: Group identifiers start at 1 and rise by one for each new group. After all ones they wrap to 1. An operation with neither flag reports group 0 and all dependencies 0.
- R6: A plain load (may-load only, no side effect) joins the current load group, without taking a new identifier, if the previous accepted memory operation was also a plain load. A load without may-store and without side effect reports `dep_load_grp` = 0, because loads may pass loads.
- R7: Any may-store operation reports `dep_store_grp` = the current store group and `dep_load_grp` = the current load group, whatever the no-alias bit is.
- R8: A may-load operation without may-store reports `dep_store_grp` = the current store group when `cfg_no_alias` is 0, and 0 when it is 1.
- R9: A load barrier (may-load with side effect) reports `dep_load_grp` = the current load group. It becomes the current load-barrier group. A store barrier becomes the current store-barrier group. A full barrier updates both.
- R10: `dep_barrier_grp` depends on which flags the operation has:
  - may-load only: the current load-barrier group.
  - may-store only: the current store-barrier group.
  - both: whichever of the two barrier groups was set most recently.
- R11: During and right after reset: both counts are 0, every current group is 0, `disp_ack` is low while reset is asserted, and the first accepted memory operation gets group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_alias | input | 1 | 1: loads never alias older stores |
| disp_valid | input | 1 | Dispatch request present |
| disp_may_load | input | 1 | Request reads memory |
| disp_may_store | input | 1 | Request writes memory |
| disp_side_fx | input | 1 | Request has side effects (barrier) |
| load_retire | input | 1 | Free one load-queue entry |
| store_commit | input | 1 | Free one store-queue entry |
| avail_status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| disp_ack | output | 1 | Request accepted this cycle |
| disp_grp | output | GID_W | Group given to the request |
| dep_load_grp | output | GID_W | Load group to wait for (0 none) |
| dep_store_grp | output | GID_W | Store group to wait for (0 none) |
| dep_barrier_grp | output | GID_W | Barrier group to wait for (0 none) |
| lq_used | output | CNT_W | Load-queue entries in use |
| sq_used | output | CNT_W | Store-queue entries in use |

## Verification
An accepted dispatch and a free event can land on the same clock edge. Examples are a load taking an entry while another retires, or a store arriving while a commit frees the full store queue. The bench drives `load_retire` and `store_commit` at random against a dense dispatch stream, with small capacities so that both queues hit full often. At each following cycle it compares the counts with its own arithmetic. The model applies two rules: a full queue rejects the request even if a free arrives in that same cycle, because the status is built from the registered count; and a take plus a free nets to no change.

// File: rtl/lsdo_pkg.sv
package lsdo_pkg;

  typedef enum logic [1:0] {
    AVAIL_OK      = 2'd0,
    AVAIL_LQ_FULL = 2'd1,
    AVAIL_SQ_FULL = 2'd2
  } avail_e;

  // Capacity zero never fills.
  function automatic logic at_capacity(input int cap, input int used);
    return (cap != 0) && (used == cap);
  endfunction

  // Load-queue shortage is reported ahead of store-queue shortage.
  function automatic avail_e pick_status(input logic ld, input logic st,
                                         input logic lq_full, input logic sq_full);
    if (ld && lq_full) return AVAIL_LQ_FULL;
    if (st && sq_full) return AVAIL_SQ_FULL;
    return AVAIL_OK;
  endfunction

endpackage

// File: rtl/lsdo_occupancy.sv
module lsdo_occupancy #(
  parameter int CAP   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  output logic [CNT_W-1:0] used,
  output logic             full
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

  logic dec_ev;
  assign dec_ev = give && (used != '0);
  assign full   = lsdo_pkg::at_capacity(CAP, int'(used));

  always_ff @(posedge clk) begin
    if (!rst_n) used <= '0;
    else        used <= used + CNT_W'(take) - CNT_W'(dec_ev);
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CAP != 0) |-> (used <= CAP_V));

  // R3
  take_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give) |=> (used == $past(used) + CNT_W'(1)));

  // R3
  net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give && used != '0) |=> $stable(used));

endmodule

// File: rtl/lsdo_group_tracker.sv
module lsdo_group_tracker #(
  parameter int GID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             op_ld,
  input  logic             op_st,
  input  logic             op_fx,
  input  logic             no_alias,
  output logic [GID_W-1:0] grp_id,
  output logic [GID_W-1:0] dep_load,
  output logic [GID_W-1:0] dep_store,
  output logic [GID_W-1:0] dep_bar
);
  typedef logic [GID_W-1:0] gid_t;

  gid_t next_q, cur_ld_q, cur_ldb_q, cur_st_q, cur_stb_q;
  logic open_q, last_bar_st_q;

  function automatic gid_t bump(input gid_t g);
    return (g == '1) ? gid_t'(1) : g + gid_t'(1);
  endfunction

  logic is_mem, plain_ld, join_grp, ld_bar, st_bar, new_grp;
  assign is_mem   = op_ld | op_st;
  assign plain_ld = op_ld & ~op_st & ~op_fx;
  assign join_grp = plain_ld & open_q;
  assign ld_bar   = op_ld & op_fx;
  assign st_bar   = op_st & op_fx;
  assign new_grp  = accept & ~join_grp;

  always_comb begin
    grp_id    = !is_mem ? '0 : (join_grp ? cur_ld_q : next_q);
    dep_load  = (op_st | ld_bar) ? cur_ld_q : '0;
    dep_store = (op_st | (op_ld & ~no_alias)) ? cur_st_q : '0;
    dep_bar   = '0;
    if (op_ld && op_st) dep_bar = last_bar_st_q ? cur_stb_q : cur_ldb_q;
    else if (op_ld)     dep_bar = cur_ldb_q;
    else if (op_st)     dep_bar = cur_stb_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q        <= gid_t'(1);
      cur_ld_q      <= '0;
      cur_ldb_q     <= '0;
      cur_st_q      <= '0;
      cur_stb_q     <= '0;
      open_q        <= 1'b0;
      last_bar_st_q <= 1'b0;
    end else if (accept) begin
      if (new_grp) next_q <= bump(next_q);
      if (op_ld)   cur_ld_q  <= grp_id;
      if (ld_bar)  cur_ldb_q <= grp_id;
      if (op_st)   cur_st_q  <= grp_id;
      if (st_bar)  cur_stb_q <= grp_id;
      if (st_bar)      last_bar_st_q <= 1'b1;
      else if (ld_bar) last_bar_st_q <= 1'b0;
      open_q <= plain_ld;
    end
  end

  // R5
  grp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mem |-> (grp_id != '0));

  // R6
  load_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && op_ld && !op_st && !op_fx) && op_ld && !op_st && !op_fx)
      |-> (grp_id == $past(grp_id)));

  // R7
  store_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && op_st) && op_st) |-> (dep_store == $past(grp_id)));

  // R10
  load_barrier_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && op_ld && op_fx) && op_ld && !op_st) |-> (dep_bar == $past(grp_id)));

endmodule

// File: rtl/lsdo_dispatch_unit.sv
module lsdo_dispatch_unit
  import lsdo_pkg::*;
#(
  parameter int LQ_CAP = 4,
  parameter int SQ_CAP = 4,
  parameter int CNT_W  = 8,
  parameter int GID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_no_alias,
  input  logic             disp_valid,
  input  logic             disp_may_load,
  input  logic             disp_may_store,
  input  logic             disp_side_fx,
  input  logic             load_retire,
  input  logic             store_commit,
  output logic [1:0]       avail_status,
  output logic             disp_ack,
  output logic [GID_W-1:0] disp_grp,
  output logic [GID_W-1:0] dep_load_grp,
  output logic [GID_W-1:0] dep_store_grp,
  output logic [GID_W-1:0] dep_barrier_grp,
  output logic [CNT_W-1:0] lq_used,
  output logic [CNT_W-1:0] sq_used
);
  logic   lq_full, sq_full, is_mem, mem_accept, lq_take, sq_take;
  avail_e status_v;

  assign status_v     = pick_status(disp_may_load, disp_may_store, lq_full, sq_full);
  assign avail_status = status_v;
  assign is_mem       = disp_may_load | disp_may_store;
  assign disp_ack     = rst_n && disp_valid && (status_v == AVAIL_OK);
  assign mem_accept   = disp_ack && is_mem;
  assign lq_take      = mem_accept && disp_may_load;
  assign sq_take      = mem_accept && disp_may_store;

  lsdo_occupancy #(.CAP(LQ_CAP), .CNT_W(CNT_W)) u_lq (
    .clk(clk), .rst_n(rst_n), .take(lq_take), .give(load_retire),
    .used(lq_used), .full(lq_full));

  lsdo_occupancy #(.CAP(SQ_CAP), .CNT_W(CNT_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .take(sq_take), .give(store_commit),
    .used(sq_used), .full(sq_full));

  lsdo_group_tracker #(.GID_W(GID_W)) u_grp (
    .clk(clk), .rst_n(rst_n), .accept(mem_accept),
    .op_ld(disp_may_load), .op_st(disp_may_store), .op_fx(disp_side_fx),
    .no_alias(cfg_no_alias), .grp_id(disp_grp), .dep_load(dep_load_grp),
    .dep_store(dep_store_grp), .dep_bar(dep_barrier_grp));

  // R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ack && !load_retire && !store_commit)
      |=> ($stable(lq_used) && $stable(sq_used)));

  // R1
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail_status != 2'd3);

endmodule

// File: tb/lsdo_dispatch_unit_tb.sv
`timescale 1ns/1ps
module lsdo_dispatch_unit_tb;
  localparam int LQC = 3, SQC = 2, CW = 8, GW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic na = 1'b0, v = 1'b0, ld = 1'b0, st = 1'b0, fx = 1'b0, ret = 1'b0, com = 1'b0;
  logic [1:0] status, status_u;
  logic ack, ack_u;
  logic [GW-1:0] grp, dl, ds, db, grp_u, dl_u, ds_u, db_u;
  logic [CW-1:0] lqu, squ, lqu_u, squ_u;

  always #2 clk = ~clk;

  lsdo_dispatch_unit #(.LQ_CAP(LQC), .SQ_CAP(SQC), .CNT_W(CW), .GID_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(na), .disp_valid(v),
    .disp_may_load(ld), .disp_may_store(st), .disp_side_fx(fx),
    .load_retire(ret), .store_commit(com), .avail_status(status), .disp_ack(ack),
    .disp_grp(grp), .dep_load_grp(dl), .dep_store_grp(ds), .dep_barrier_grp(db),
    .lq_used(lqu), .sq_used(squ));

  lsdo_dispatch_unit #(.LQ_CAP(0), .SQ_CAP(0), .CNT_W(CW), .GID_W(GW)) u_unb (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(na), .disp_valid(v),
    .disp_may_load(ld), .disp_may_store(st), .disp_side_fx(fx),
    .load_retire(ret), .store_commit(com), .avail_status(status_u), .disp_ack(ack_u),
    .disp_grp(grp_u), .dep_load_grp(dl_u), .dep_store_grp(ds_u), .dep_barrier_grp(db_u),
    .lq_used(lqu_u), .sq_used(squ_u));

  int checks = 0, errs = 0;
  int m_lq = 0, m_sq = 0, u_lq = 0, u_sq = 0;
  int m_next = 1, m_cl = 0, m_clb = 0, m_cs = 0, m_csb = 0;
  bit m_open = 0, m_lastst = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit il, input bit is, input bit ifx,
                      input bit ina, input bit ir, input bit ic);
    int e_st, e_grp, e_dl, e_ds, e_db;
    bit lf, sf, mem, acc, jn, ok_st;
    chk(int'(lqu) == m_lq, "R3 load count", int'(lqu), m_lq);
    chk(int'(squ) == m_sq, "R3 store count", int'(squ), m_sq);
    chk(int'(lqu_u) == u_lq, "R3 unbounded load count", int'(lqu_u), u_lq);
    v = iv; ld = il; st = is; fx = ifx; na = ina; ret = ir; com = ic;
    #1;
    lf  = (m_lq == LQC);
    sf  = (m_sq == SQC);
    mem = il | is;
    e_st = (il && lf) ? 1 : ((is && sf) ? 2 : 0);
    chk(int'(status) == e_st, (e_st != 0) ? "R2 full status" : "R1 status", int'(status), e_st);
    chk(status_u == 2'd0, "R2 capacity zero never full", int'(status_u), 0);
    acc = iv && (e_st == 0);
    chk(ack == acc, "R4 ack", int'(ack), int'(acc));
    jn = il && !is && !ifx && m_open;
    e_grp = !mem ? 0 : (jn ? m_cl : m_next);
    chk(int'(grp) == e_grp, jn ? "R6 load join" : "R5 group id", int'(grp), e_grp);
    e_dl = (is || (il && ifx)) ? m_cl : 0;
    chk(int'(dl) == e_dl, (il && ifx && !is) ? "R9 load barrier dep" : "R7 load dep", int'(dl), e_dl);
    e_ds = (is || (il && !ina)) ? m_cs : 0;
    chk(int'(ds) == e_ds, is ? "R7 store dep" : "R8 alias dep", int'(ds), e_ds);
    e_db = (il && is) ? (m_lastst ? m_csb : m_clb) : (il ? m_clb : (is ? m_csb : 0));
    chk(int'(db) == e_db, "R10 barrier dep", int'(db), e_db);
    ok_st = acc && mem;
    if (ok_st) begin
      if (!jn) m_next = (m_next == 255) ? 1 : m_next + 1;
      if (il) m_cl = e_grp;
      if (il && ifx) m_clb = e_grp;
      if (is) m_cs = e_grp;
      if (is && ifx) m_csb = e_grp;
      if (is && ifx) m_lastst = 1; else if (il && ifx) m_lastst = 0;
      m_open = il && !is && !ifx;
    end
    m_lq = m_lq + ((ok_st && il) ? 1 : 0) - ((ir && m_lq != 0) ? 1 : 0);
    m_sq = m_sq + ((ok_st && is) ? 1 : 0) - ((ic && m_sq != 0) ? 1 : 0);
    u_lq = u_lq + ((iv && il) ? 1 : 0) - ((ir && u_lq != 0) ? 1 : 0);
    u_sq = u_sq + ((iv && is) ? 1 : 0) - ((ic && u_sq != 0) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    v = 1'b1; ld = 1'b1;
    repeat (3) @(negedge clk);
    chk(ack == 1'b0, "R11 ack low in reset", int'(ack), 0);
    chk(lqu == '0 && squ == '0, "R11 counts zero", int'(lqu) + int'(squ), 0);
    chk(dl == '0 && ds == '0 && db == '0, "R11 groups zero", int'(dl) + int'(ds) + int'(db), 0);
    rst_n = 1'b1; v = 1'b0; ld = 1'b0;
    @(negedge clk);
    step(1, 0, 1, 0, 0, 0, 0);
    chk(m_next == 2, "R11 first group is 1", m_next, 2);
    // fill both queues, then free and take on the same edge
    step(1, 1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 1, 0); step(1, 0, 1, 0, 0, 0, 0); step(1, 1, 1, 0, 0, 1, 1);
    step(1, 0, 1, 0, 0, 1, 1); step(1, 0, 1, 0, 0, 1, 1);
    // sweep of all flag combinations
    for (int r = 0; r < 12; r++)
      for (int c = 0; c < 16; c++)
        step(1, c[0], c[1], c[2], c[3], r[0], r[1]);
    // random traffic, long enough to wrap group ids
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) != 0, $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
           $urandom % 2, ($urandom % 5) < 2, ($urandom % 5) < 2);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule